// File: doc/BRIEF.md
# DTMF Key Steering and Code Latch

This block follows a tone-pair detector and decides when a keypress is genuine. The detector supplies a level that is high while a valid tone pair is present (`pair_vld`) and a 4-bit key index. A counter-based guard timer takes the place of an analog RC steering network. It requires the tone to persist for a programmable present guard time before a key is registered. It then requires silence to persist for a separate, programmable absent guard time before the key is released. Short noise bursts are rejected, and short dropouts inside a held tone are ridden through.

On registration the block latches a 4-bit key code and raises `guard_on`. After a programmable settling delay it raises `key_ready`. The latched code is presented on a bus output with a matching output-enable, so the pad or bus logic outside can tri-state it. An inhibit input hides the four extended keys, and a power-down input halts all detection activity.

Key index convention: indices 0 to 9 are the digits 0 to 9, index 10 is `*`, index 11 is `#`, and indices 12, 13, 14 and 15 are A, B, C and D.

Top module: `dtmf_steer`

## Requirements
- R1: A key is registered only when `tone_seen` has been high on `tp_cycles` consecutive cycles (values below 1 act as 1). A burst one cycle shorter causes no latch update and no `key_ready` pulse. `tone_seen` follows `pair_vld` with one cycle of delay.
- R2: After registration, `guard_on` stays high for as long as `tone_seen` stays high.
- R3: A held key is released only after `tone_seen` has been low on `ta_cycles` consecutive cycles. A shorter gap is a dropout: `key_ready` stays high and no new registration happens.
- R4: `tp_cycles` and `ta_cycles` are independent. A short present time can be combined with a long absent time.
- R5: At registration the latch loads the code for the key. Digits 1 to 9 load 0001 to 1001, digit 0 loads 1010, `*` loads 1011, `#` loads 1100, A loads 1101, B loads 1110, C loads 1111 and D loads 0000.
- R6: `key_ready` rises exactly `settle_cycles` clock cycles after `guard_on` first rises for a key. It falls in the cycle in which the absent guard time expires.
- R7: `q_oe` equals `out_en`. While `out_en` is high, `q_out` carries the latched code whatever the state of `tone_seen`. While `out_en` is low, `q_out` is 0000.
- R8: While `inhibit` is high, key indices 12 to 15 do not raise `tone_seen`, and the latch keeps its previous code. All other keys register normally.
- R9: While `pwr_down` is high, `tone_seen`, `guard_on` and `key_ready` are low and the timer stays idle. The latched code is retained.
- R10: A synchronous reset clears the latch to 0000, drives `guard_on` and `key_ready` low, and leaves the timer idle in the tone-absent state.
- R11: A new key can be registered only after the previous key has been released. If the key index changes while the tone stays present, the latched code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_down | input | 1 | Halts detection and holds the timer idle |
| inhibit | input | 1 | Suppresses keys A to D |
| pair_vld | input | 1 | Tone pair present, from the detector |
| key_idx | input | 4 | Key index of the present tone pair |
| tp_cycles | input | CW | Present guard time in cycles |
| ta_cycles | input | CW | Absent guard time in cycles |
| settle_cycles | input | CW | Delay from latch load to `key_ready` |
| out_en | input | 1 | Enables the code bus |
| tone_seen | output | 1 | Early steering: qualified tone present |
| guard_on | output | 1 | Key registered and tone still present |
| key_ready | output | 1 | Delayed steering flag |
| q_out | output | 4 | Latched key code bus value |
| q_oe | output | 1 | Bus drive enable |

## Verification
All sixteen key indices are pressed with long tones, which separates the code mapping per key, including the wrap of D to 0000. Bursts of exactly the present guard time and one cycle less tell registration apart from rejection. Gaps of one cycle less than the absent guard time, and of exactly that time, tell a dropout apart from a release. A key change inside a held tone shows that no re-registration happens. The guard times are then swapped to short-present and long-absent, which shows that the two settings are independent. Inhibited extended keys, power-down and a disabled bus are each checked against the code left in the latch.

// File: rtl/dtmf_steer_pkg.sv
`timescale 1ns/1ps
package dtmf_steer_pkg;
  localparam int KEY_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_QUAL_ON  = 2'd1,
    ST_HELD     = 2'd2,
    ST_QUAL_OFF = 2'd3
  } steer_st_e;

  // Maps a key index (0-9 digits, 10 '*', 11 '#', 12-15 A-D) to the bus nibble.
  function automatic logic [KEY_W-1:0] key_code(input logic [KEY_W-1:0] idx);
    if (idx == '0)
      return KEY_W'(10);
    else if (idx <= KEY_W'(9))
      return idx;
    else
      return idx + KEY_W'(1);
  endfunction

  function automatic logic is_ext_key(input logic [KEY_W-1:0] idx);
    return idx[3] & idx[2];
  endfunction

  // True when one more counted cycle reaches the limit (a limit of 0 acts as 1).
  function automatic logic limit_hit(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction
endpackage

// File: rtl/dtmf_tone_gate.sv
`timescale 1ns/1ps
module dtmf_tone_gate
  import dtmf_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_down,
  input  logic             inhibit,
  input  logic             pair_vld,
  input  logic [KEY_W-1:0] key_idx,
  output logic             tone_q,
  output logic [KEY_W-1:0] key_q
);
  logic blocked;

  assign blocked = pwr_down | (inhibit & is_ext_key(key_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_q <= 1'b0;
      key_q  <= '0;
    end else begin
      tone_q <= pair_vld & ~blocked;
      key_q  <= key_idx;
    end
  end
endmodule

// File: rtl/dtmf_guard_fsm.sv
`timescale 1ns/1ps
module dtmf_guard_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_down,
  input  logic          tone_q,
  input  logic [CW-1:0] tp_lim,
  input  logic [CW-1:0] ta_lim,
  output logic          reg_evt,
  output logic          rel_evt,
  output logic          guard_on,
  output logic          key_held
);
  steer_st_e     state;
  logic [CW-1:0] cnt;
  logic          absent_side;
  logic          present_side;

  assign absent_side  = (state == ST_IDLE) || (state == ST_QUAL_ON);
  assign present_side = (state == ST_HELD) || (state == ST_QUAL_OFF);

  assign reg_evt  = !pwr_down && absent_side  &&  tone_q && limit_hit(32'(cnt), 32'(tp_lim));
  assign rel_evt  = !pwr_down && present_side && !tone_q && limit_hit(32'(cnt), 32'(ta_lim));
  assign guard_on = (state == ST_HELD);
  assign key_held = present_side;

  always_ff @(posedge clk) begin
    if (rst || pwr_down) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else if (absent_side) begin
      if (!tone_q) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (reg_evt) begin
        state <= ST_HELD;
        cnt   <= '0;
      end else begin
        state <= ST_QUAL_ON;
        cnt   <= cnt + CW'(1);
      end
    end else begin
      if (tone_q) begin
        state <= ST_HELD;
        cnt   <= '0;
      end else if (rel_evt) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else begin
        state <= ST_QUAL_OFF;
        cnt   <= cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dtmf_code_latch.sv
`timescale 1ns/1ps
module dtmf_code_latch
  import dtmf_steer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr_down,
  input  logic             reg_evt,
  input  logic             rel_evt,
  input  logic [KEY_W-1:0] key_q,
  input  logic [CW-1:0]    settle_lim,
  output logic [KEY_W-1:0] code,
  output logic             ready
);
  logic          pend;
  logic [CW-1:0] scnt;

  always_ff @(posedge clk) begin
    if (rst)
      code <= '0;
    else if (reg_evt)
      code <= key_code(key_q);
  end

  always_ff @(posedge clk) begin
    if (rst || pwr_down || rel_evt) begin
      ready <= 1'b0;
      pend  <= 1'b0;
      scnt  <= '0;
    end else if (reg_evt) begin
      ready <= 1'b0;
      pend  <= 1'b1;
      scnt  <= '0;
    end else if (pend) begin
      if (limit_hit(32'(scnt), 32'(settle_lim))) begin
        ready <= 1'b1;
        pend  <= 1'b0;
      end else begin
        scnt  <= scnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/dtmf_steer.sv
`timescale 1ns/1ps
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_down,
  input  logic          inhibit,
  input  logic          pair_vld,
  input  logic [3:0]    key_idx,
  input  logic [CW-1:0] tp_cycles,
  input  logic [CW-1:0] ta_cycles,
  input  logic [CW-1:0] settle_cycles,
  input  logic          out_en,
  output logic          tone_seen,
  output logic          guard_on,
  output logic          key_ready,
  output logic [3:0]    q_out,
  output logic          q_oe
);
  logic             tone_q;
  logic [KEY_W-1:0] key_q;
  logic             reg_evt;
  logic             rel_evt;
  logic             key_held;
  logic [KEY_W-1:0] code_r;

  dtmf_tone_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .inhibit  (inhibit),
    .pair_vld (pair_vld),
    .key_idx  (key_idx),
    .tone_q   (tone_q),
    .key_q    (key_q)
  );

  dtmf_guard_fsm #(.CW(CW)) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .pwr_down (pwr_down),
    .tone_q   (tone_q),
    .tp_lim   (tp_cycles),
    .ta_lim   (ta_cycles),
    .reg_evt  (reg_evt),
    .rel_evt  (rel_evt),
    .guard_on (guard_on),
    .key_held (key_held)
  );

  dtmf_code_latch #(.CW(CW)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .pwr_down   (pwr_down),
    .reg_evt    (reg_evt),
    .rel_evt    (rel_evt),
    .key_q      (key_q),
    .settle_lim (settle_cycles),
    .code       (code_r),
    .ready      (key_ready)
  );

  assign tone_seen = tone_q;
  assign q_oe      = out_en;
  assign q_out     = out_en ? code_r : '0;
endmodule

// File: rtl/dtmf_steer_chk.sv
`timescale 1ns/1ps
module dtmf_steer_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_down,
  input logic       inhibit,
  input logic       pair_vld,
  input logic [3:0] key_idx,
  input logic       tone_seen,
  input logic       guard_on,
  input logic       key_ready,
  input logic       key_held,
  input logic       reg_evt,
  input logic       rel_evt,
  input logic [3:0] code
);
  a_r1_reg_needs_tone: assert property (@(posedge clk) disable iff (rst)
    reg_evt |-> tone_seen);

  a_r2_guard_holds: assert property (@(posedge clk) disable iff (rst || pwr_down)
    (guard_on && tone_seen) |=> guard_on);

  a_r3_release_in_quiet: assert property (@(posedge clk) disable iff (rst)
    rel_evt |-> !tone_seen);

  a_r11_no_reg_while_held: assert property (@(posedge clk) disable iff (rst)
    key_held |-> !reg_evt);

  a_r5_latch_only_on_reg: assert property (@(posedge clk) disable iff (rst)
    !reg_evt |=> $stable(code));

  a_r6_ready_within_hold: assert property (@(posedge clk) disable iff (rst)
    key_ready |-> key_held);

  a_r8_inhibit_blocks_ext: assert property (@(posedge clk) disable iff (rst)
    (inhibit && pair_vld && key_idx[3:2] == 2'b11) |=> !tone_seen);

  a_r9_powerdown_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!tone_seen && !guard_on && !key_ready));

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (code == 4'd0 && !guard_on && !key_ready && !key_held));
endmodule

bind dtmf_steer dtmf_steer_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .pwr_down  (pwr_down),
  .inhibit   (inhibit),
  .pair_vld  (pair_vld),
  .key_idx   (key_idx),
  .tone_seen (tone_seen),
  .guard_on  (guard_on),
  .key_ready (key_ready),
  .key_held  (key_held),
  .reg_evt   (reg_evt),
  .rel_evt   (rel_evt),
  .code      (code_r)
);

// File: tb/test_dtmf_steer.sv
`timescale 1ns/1ps
module test_dtmf_steer;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pwr_down = 1'b0;
  logic          inhibit = 1'b0;
  logic          pair_vld = 1'b0;
  logic [3:0]    key_idx = '0;
  logic [CW-1:0] tp_cycles = 16'd5;
  logic [CW-1:0] ta_cycles = 16'd4;
  logic [CW-1:0] settle_cycles = 16'd3;
  logic          out_en = 1'b1;
  logic          tone_seen, guard_on, key_ready, q_oe;
  logic [3:0]    q_out;

  int n_checks = 0;
  int n_fail   = 0;
  int wd       = 0;
  int cyc      = 0;
  int rise_cyc = 0;
  logic ready_d = 1'b0;
  logic guard_d = 1'b0;
  logic [3:0] exp_q[$];

  always #5 clk = ~clk;

  dtmf_steer #(.CW(CW)) i_dtmf_steer (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .inhibit(inhibit),
    .pair_vld(pair_vld), .key_idx(key_idx), .tp_cycles(tp_cycles),
    .ta_cycles(ta_cycles), .settle_cycles(settle_cycles), .out_en(out_en),
    .tone_seen(tone_seen), .guard_on(guard_on), .key_ready(key_ready),
    .q_out(q_out), .q_oe(q_oe)
  );

  function automatic logic [3:0] expect_code(input int idx);
    case (idx)
      0: return 4'b1010;   10: return 4'b1011;  11: return 4'b1100;
      12: return 4'b1101;  13: return 4'b1110;  14: return 4'b1111;
      15: return 4'b0000;  default: return 4'(idx);
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on each key_ready rise and times the settle delay.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (guard_on && !guard_d && !key_ready) rise_cyc = cyc;
      if (key_ready && !ready_d) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected registration", int'(q_out), -1);
        end else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          check(q_out == e, "R5 latched code", int'(q_out), int'(e));
          check(cyc - rise_cyc == int'(settle_cycles), "R6 settle delay",
                cyc - rise_cyc, int'(settle_cycles));
        end
      end
    end
    ready_d = key_ready;
    guard_d = guard_on;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 50000);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // Driver: tone for 'on' cycles then silence for 'off' cycles; pushes the expected code.
  task automatic press(input int idx, input int on, input int off, input bit quiet);
    bit will_reg;
    will_reg = (on >= int'(tp_cycles)) && !pwr_down && !(inhibit && idx >= 12);
    if (will_reg) exp_q.push_back(expect_code(idx));
    @(negedge clk);
    pair_vld = 1'b1;
    key_idx  = 4'(idx);
    for (int i = 0; i < on; i++) begin
      @(negedge clk);
      if (quiet) check(!tone_seen && !guard_on, "R8/R9 tone suppressed", int'(tone_seen), 0);
    end
    if (will_reg && on > int'(tp_cycles))
      check(guard_on == 1'b1, "R2 guard held while tone present", int'(guard_on), 1);
    pair_vld = 1'b0;
    repeat (off) @(negedge clk);
    if (off > int'(ta_cycles))
      check(key_ready == 1'b0, "R3 released after absent time", int'(key_ready), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!tone_seen && !guard_on && !key_ready, "R10 reset outputs low",
          int'({tone_seen, guard_on, key_ready}), 0);
    check(q_out == 4'd0 && q_oe, "R10 latch cleared", int'(q_out), 0);
    rst = 1'b0;

    // R5: every key index
    for (int k = 0; k < 16; k++) press(k, 8, 6, 1'b0);

    // R1: burst of tp-1 discarded, burst of exactly tp registered
    press(7, 8, 6, 1'b0);
    press(3, 4, 6, 1'b0);
    check(q_out == 4'd7, "R1 short burst no latch update", int'(q_out), 7);
    press(3, 5, 6, 1'b0);
    check(q_out == 4'd3, "R1 burst of tp registers", int'(q_out), 3);

    // R3/R6: dropout of ta-1 ridden through, then exact ta releases
    exp_q.push_back(expect_code(9));
    @(negedge clk); pair_vld = 1'b1; key_idx = 4'd9;
    repeat (8) @(negedge clk);
    pair_vld = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(key_ready == 1'b1, "R3 dropout keeps key", int'(key_ready), 1);
    end
    pair_vld = 1'b1;
    repeat (6) @(negedge clk);
    pair_vld = 1'b0;
    repeat (4) @(negedge clk);
    check(key_ready == 1'b1, "R6 flag held until absent time expires", int'(key_ready), 1);
    @(negedge clk);
    check(key_ready == 1'b0, "R6 flag falls at release", int'(key_ready), 0);
    repeat (2) @(negedge clk);

    // R11: key change during a held tone
    exp_q.push_back(expect_code(1));
    pair_vld = 1'b1; key_idx = 4'd1;
    repeat (8) @(negedge clk);
    key_idx = 4'd2;
    repeat (8) @(negedge clk);
    pair_vld = 1'b0;
    repeat (6) @(negedge clk);
    check(q_out == 4'd1, "R11 no re-registration while held", int'(q_out), 1);

    // R7: bus enable and code visible regardless of tone
    out_en = 1'b0;
    @(negedge clk);
    check(q_out == 4'd0 && !q_oe, "R7 bus disabled", int'({q_oe, q_out}), 0);
    out_en = 1'b1;
    pair_vld = 1'b1; key_idx = 4'd4;
    repeat (2) @(negedge clk);
    check(tone_seen && q_out == 4'd1, "R7 bus shows latch during tone", int'(q_out), 1);
    repeat (2) @(negedge clk);
    pair_vld = 1'b0;
    repeat (6) @(negedge clk);

    // R8: inhibit hides A-D only
    inhibit = 1'b1;
    press(13, 8, 6, 1'b1);
    check(q_out == 4'd1, "R8 inhibited key keeps code", int'(q_out), 1);
    press(5, 8, 6, 1'b0);
    inhibit = 1'b0;
    press(12, 8, 6, 1'b0);
    check(q_out == 4'b1101, "R8 key A after inhibit cleared", int'(q_out), 13);

    // R9: power-down
    pwr_down = 1'b1;
    press(6, 8, 6, 1'b1);
    check(q_out == 4'b1101 && !key_ready, "R9 latch retained in power-down", int'(q_out), 13);
    pwr_down = 1'b0;

    // R4: short present time with long absent time
    tp_cycles = 16'd2; ta_cycles = 16'd8; settle_cycles = 16'd1;
    repeat (2) @(negedge clk);
    press(8, 2, 10, 1'b0);
    check(q_out == 4'd8, "R4 two-cycle burst registers", int'(q_out), 8);
    exp_q.push_back(expect_code(2));
    pair_vld = 1'b1; key_idx = 4'd2;
    repeat (4) @(negedge clk);
    pair_vld = 1'b0;
    repeat (5) @(negedge clk);
    check(key_ready == 1'b1, "R4 long absent time rides gap", int'(key_ready), 1);
    pair_vld = 1'b1;
    repeat (3) @(negedge clk);
    pair_vld = 1'b0;
    repeat (10) @(negedge clk);
    check(key_ready == 1'b0, "R4 release after long absent time", int'(key_ready), 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1 all expected registrations seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule